// File: doc/BRIEF.md
# Wired-AND SCL Clock Synchronizer

This block produces the serial clock for a two-wire bus master that shares its clock line with other masters. The line is open-drain, so any device that pulls it low holds it low for everyone. The block drives the line low for a programmed number of system-clock cycles and then lets go. It waits until it sees the line actually high, and only then counts a programmed high period. If another device pulls the line low during that count, the block drops the count and pulls low at once. The result is that every master follows one common bus clock. Its low time is set by the master with the longest low period, and its high time by the master with the shortest high period.

The raw line level passes through a synchronizer chain of `SYNC_STAGES` flops before the phase logic uses it. With the default of two stages, a line that this block releases by itself is seen high three cycles after the release. A high level is accepted only after the synchronized line has been seen low since the current low phase began. This keeps a stale high from before the low phase from starting a high count early.

The block also gives one-cycle markers on each edge of its own drive, for a data shifter. These are plain strobes with no back-pressure; the block emits no data stream and has no valid/ready interface. Both counts are sampled as written, and a count of zero is treated as one. The enable input starts clock generation. Dropping it releases the line and clears all phase state.

Top module: `scl_sync_gen`

## Requirements
- R1: During reset, and from the first clock edge after `enable` is sampled low, `scl_oe` is 0. When `enable` is sampled high from idle, `scl_oe` becomes 1 on the next edge. Every phase counter is cleared while the block is disabled, so re-enabling gives a full low phase.
- R2: Each low phase holds `scl_oe` at 1 for exactly max(`low_cnt`,1) cycles, whatever the bus does. A low phase is cut short only by disable.
- R3: After release, the high count starts only once the synchronized line reads high, having been read low since the low phase began. With the default two synchronizer stages: a block alone on the bus keeps `scl_oe` at 0 for max(`high_cnt`,1)+3 cycles. If another device holds the line low past this block's release, `scl_oe` returns to 1 on the (max(`high_cnt`,1)+3)-th clock edge after the line rises.
- R4: When max(`high_cnt`,1) high cycles have been counted with the line high, `scl_oe` goes to 1 and a new low phase starts.
- R5: If the line goes low while the high period is being counted, the count is abandoned. With the default two synchronizer stages, `scl_oe` becomes 1 on the third clock edge after the line falls, and a full low phase of max(`low_cnt`,1) cycles follows.
- R6: `fall_pulse` is 1 for exactly the first cycle in which `scl_oe` is 1, and `rise_pulse` for exactly the first cycle in which `scl_oe` is 0 after being 1. The two are never 1 together, and both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 runs clock generation, 0 releases the line and idles |
| low_cnt | input | CW | Low-phase length in cycles (0 acts as 1) |
| high_cnt | input | CW | High-phase length in cycles (0 acts as 1) |
| scl_in | input | 1 | Raw level of the shared clock line |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| fall_pulse | output | 1 | One-cycle strobe when this block starts pulling low |
| rise_pulse | output | 1 | One-cycle strobe when this block releases the line |

## Verification
The bench sweeps every low and high count from 0 to 4 with the block alone on the line, where the bus level is the inverse of `scl_oe`. It checks low and released run lengths against max(n,1) and max(n,1)+3. A design that ignored the zero clamp, or that counted high time from the release instead of from the observed high, would miss those lengths by one or three cycles. A low count of 1 is the sharpest case for the stale-high hazard: a design without the low-seen gate would start its high count on a high left over from the previous phase.

An emulated second master holds the line low past the release, and the bench checks that the high count is referenced to the line's rise. It also pulls the line low in mid-high to check the three-edge reaction and the full low phase that follows. The edge strobes are compared against the drive's own transitions on every cycle. Disabling in mid-low checks for an immediate release and a full first low phase after re-enable.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  function automatic logic [31:0] at_least_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/scl_bus_sync.sv
module scl_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_out
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level_out = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_sync_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] low_len,
  input  logic [CW-1:0] high_len,
  input  logic          line_hi,
  output logic          drive_now,
  output logic          drive_nxt
);

  phase_t        phase_q, phase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          seen_lo_q, seen_lo_n;

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    seen_lo_n = seen_lo_q;
    if (!enable) begin
      phase_n   = PH_IDLE;
      cnt_n     = '0;
      seen_lo_n = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_n   = PH_LOW;
          cnt_n     = CW'(1);
          seen_lo_n = 1'b0;
        end
        PH_LOW: begin
          if (!line_hi) seen_lo_n = 1'b1;
          if (cnt_q >= low_len) begin
            phase_n = PH_WAIT;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        PH_WAIT: begin
          if (!line_hi) begin
            seen_lo_n = 1'b1;
          end else if (seen_lo_q) begin
            phase_n = PH_HIGH;
            cnt_n   = CW'(1);
          end
        end
        PH_HIGH: begin
          if (!line_hi || (cnt_q >= high_len)) begin
            phase_n   = PH_LOW;
            cnt_n     = CW'(1);
            seen_lo_n = 1'b0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: begin
          phase_n   = PH_IDLE;
          cnt_n     = '0;
          seen_lo_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      seen_lo_q <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      seen_lo_q <= seen_lo_n;
    end
  end

  assign drive_now = (phase_q == PH_LOW);
  assign drive_nxt = (phase_n == PH_LOW);

endmodule

// File: rtl/scl_edge_mark.sv
module scl_edge_mark (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_now,
  input  logic drive_nxt,
  output logic fall_mark,
  output logic rise_mark
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_mark <= 1'b0;
      rise_mark <= 1'b0;
    end else begin
      fall_mark <= drive_nxt & ~drive_now;
      rise_mark <= drive_now & ~drive_nxt;
    end
  end

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_sync_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          fall_pulse,
  output logic          rise_pulse
);

  logic [CW-1:0] low_eff, high_eff;
  logic          line_hi, drive_now, drive_nxt;

  assign low_eff  = CW'(at_least_one(32'(low_cnt)));
  assign high_eff = CW'(at_least_one(32'(high_cnt)));

  scl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_in    (scl_in),
    .level_out (line_hi)
  );

  scl_phase_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .low_len   (low_eff),
    .high_len  (high_eff),
    .line_hi   (line_hi),
    .drive_now (drive_now),
    .drive_nxt (drive_nxt)
  );

  scl_edge_mark u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_now (drive_now),
    .drive_nxt (drive_nxt),
    .fall_mark (fall_pulse),
    .rise_mark (rise_pulse)
  );

  assign scl_oe = drive_now;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [CW-1:0] low_cnt,
  input logic          scl_oe,
  input logic          fall_pulse,
  input logic          rise_pulse
);

  logic [31:0] lo_run;
  logic        prev_oe, prev_en;
  logic [31:0] want_lo;

  assign want_lo = (low_cnt == '0) ? 32'd1 : 32'(low_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= '0;
      prev_oe <= 1'b0;
      prev_en <= 1'b0;
    end else begin
      lo_run  <= scl_oe ? lo_run + 32'd1 : 32'd0;
      prev_oe <= scl_oe;
      prev_en <= enable;
    end
  end

  a_r1_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_oe);

  a_r2_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && prev_oe && prev_en) |-> (lo_run == want_lo));

  a_r6_fall_mark: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse == (scl_oe && !prev_oe));

  a_r6_rise_mark: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse == (!scl_oe && prev_oe));

  a_r6_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_pulse && rise_pulse));

endmodule

bind scl_sync_gen scl_sync_gen_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .low_cnt    (low_cnt),
  .scl_oe     (scl_oe),
  .fall_pulse (fall_pulse),
  .rise_pulse (rise_pulse)
);

// File: tb/scl_sync_gen_test.sv
module scl_sync_gen_test;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [CW-1:0] low_cnt = '0;
  logic [CW-1:0] high_cnt = '0;
  logic          ext_low = 1'b0;
  logic          scl_oe, fall_pulse, rise_pulse;
  logic          bus;

  int n_checks = 0;
  int n_fail = 0;
  logic edge_watch = 1'b0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  assign bus = ~(scl_oe | ext_low);

  always #4 clk = ~clk;

  scl_sync_gen #(.CW(CW), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .low_cnt    (low_cnt),
    .high_cnt   (high_cnt),
    .scl_in     (bus),
    .scl_oe     (scl_oe),
    .fall_pulse (fall_pulse),
    .rise_pulse (rise_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (scl_oe == v && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // R6: strobe check against the drive's own transitions, every cycle
  always @(negedge clk) begin
    if (edge_watch) begin
      check("R6 fall_pulse", int'(fall_pulse), int'(scl_oe && !prev_oe));
      check("R6 rise_pulse", int'(rise_pulse), int'(!scl_oe && prev_oe));
    end
    prev_oe <= scl_oe;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int le, he;
    repeat (3) @(negedge clk);
    check("R1 reset oe", int'(scl_oe), 0);
    check("R1 reset fall", int'(fall_pulse), 0);
    check("R1 reset rise", int'(rise_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    edge_watch = 1'b1;

    // alone on the bus: sweep counts 0..4
    for (int l = 0; l <= 4; l++) begin
      for (int h = 0; h <= 4; h++) begin
        le = (l == 0) ? 1 : l;
        he = (h == 0) ? 1 : h;
        low_cnt  = CW'(l);
        high_cnt = CW'(h);
        enable   = 1'b1;
        @(negedge clk);
        check("R1 start drive", int'(scl_oe), 1);
        run_len(1'b1, n);
        check("R2 low length", n, le);
        run_len(1'b0, n);
        check("R3 R4 released length", n, he + 3);
        run_len(1'b1, n);
        check("R2 second low length", n, le);
        run_len(1'b0, n);
        check("R4 second released length", n, he + 3);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle after disable", int'(scl_oe), 0);
      end
    end

    // disable in mid-low, then re-enable: full low phase
    low_cnt = CW'(6); high_cnt = CW'(2);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mid-low drive", int'(scl_oe), 1);
    enable = 1'b0;
    @(negedge clk);
    check("R1 release on disable", int'(scl_oe), 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b1, n);
    check("R1 full low after re-enable", n, 6);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    // stretch: another device holds the line low past release
    low_cnt = CW'(2); high_cnt = CW'(3);
    enable = 1'b1;
    @(negedge clk);
    ext_low = 1'b1;
    run_len(1'b1, n);
    check("R2 low length under stretch", n, 2);
    repeat (6) begin
      check("R3 no drive while held", int'(scl_oe), 0);
      @(negedge clk);
    end
    ext_low = 1'b0;
    @(negedge clk);
    run_len(1'b0, n);
    check("R3 high counted from line rise", n, 3 + 2);
    run_len(1'b1, n);
    check("R2 low after stretch", n, 2);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    // abandon: line pulled low in the middle of the high count
    low_cnt = CW'(2); high_cnt = CW'(10);
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b1, n);
    check("R2 low before abandon", n, 2);
    repeat (6) @(negedge clk);
    check("R5 still released", int'(scl_oe), 0);
    ext_low = 1'b1;
    @(negedge clk);
    ext_low = 1'b0;
    check("R5 no drive edge 1", int'(scl_oe), 0);
    @(negedge clk);
    check("R5 no drive edge 2", int'(scl_oe), 0);
    @(negedge clk);
    check("R5 drive on third edge", int'(scl_oe), 1);
    run_len(1'b1, n);
    check("R5 full low after abandon", n, 2);
    run_len(1'b0, n);
    check("R4 high after abandon", n, 10 + 3);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule